// File: doc/BRIEF.md
# Prescaled Timer Time Base

This block is a 16-bit up-counting time base. A prescaler divides the clock so that the counter advances once every (divisor + 1) enabled cycles. When the counter reaches a programmable reload limit, it wraps to zero on that advance and raises a one-cycle update pulse.

Software reaches three word registers through a simple register bus: address, write enable, write data and combinational read data. The bus has no handshake. A write completes on the edge where the enable is sampled high, and no back-pressure is ever applied. The divisor and the limit are double-buffered. A bus write lands in a staging register, and the active copy picks up the new value only at an update event. An update event is either a counter wrap or a single-cycle software update request. While the active limit is zero, the counter stays where it is.

Top module: `ptb_timebase`

## Requirements
- R1: After reset, all three registers read 0x0000 and `upd_pulse` is low.
- R2: Byte offset 0x24 selects the counter, 0x28 selects the divisor and 0x2C selects the limit. Any other offset reads 0x0000, and a write to it changes nothing.
- R3: With enable high, the counter advances once every (active divisor + 1) clock cycles.
- R4: A write to the divisor or the limit leaves the active copy unchanged until the next update event.
- R5: On an advance where the counter is at or above a nonzero active limit, the counter becomes zero instead of incrementing.
- R6: While the active limit is zero, the counter does not advance.
- R7: Reading the divisor or limit offset returns the staged value last written, not the active one.
- R8: Each update event produces `upd_pulse` high for one cycle. The pulse appears after the same clock edge that loads the new counter value.
- R9: While enable is low, both the counter and the internal prescaler count hold their values.
- R10: A software update request forces the counter and the prescaler count to zero, copies both staged values to the active copies and pulses `upd_pulse`. It takes priority over a counter write in the same cycle.
- R11: A counter write takes effect on the next clock edge. It overrides any advance in that cycle and suppresses a wrap in that cycle.
- R12: A wrap copies the staged divisor and limit into the active copies and restarts the prescaler count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counting enable |
| sw_upd | input | 1 | Single-cycle software update request |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| upd_pulse | output | 1 | One-cycle update-event pulse |

## Verification
Each counter advance, wrap, counter write and software update becomes visible one clock edge after its cause. Bus reads are combinational, so the bench reads registers at the falling edge that follows the edge under test. The bench numbers every rising edge. A driver pushes, into a queue, the edge number after which each update pulse is due, worked out from the divisor and limit as (limit + 1) × (divisor + 1) cycles per period. A monitor pops one entry per observed pulse and flags any pulse that arrives early, late or unexpected, and any pulse that never arrives.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
  localparam int PTB_AW = 8;

  localparam logic [PTB_AW-1:0] OFS_CNT = 8'h24;
  localparam logic [PTB_AW-1:0] OFS_DIV = 8'h28;
  localparam logic [PTB_AW-1:0] OFS_LIM = 8'h2C;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CNT,
    SEL_DIV,
    SEL_LIM
  } ptb_sel_e;

  function automatic ptb_sel_e ptb_decode(input logic [PTB_AW-1:0] a);
    case (a)
      OFS_CNT: return SEL_CNT;
      OFS_DIV: return SEL_DIV;
      OFS_LIM: return SEL_LIM;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ptb_regs.sv
module ptb_regs
  import ptb_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PTB_AW-1:0] addr,
  input  logic              we,
  input  logic [W-1:0]      wdata,
  input  logic              upd_evt,
  input  logic [W-1:0]      cnt_q,
  output logic [W-1:0]      div_act,
  output logic [W-1:0]      lim_act,
  output logic              cnt_we,
  output logic [W-1:0]      rdata
);
  ptb_sel_e       sel;
  logic [W-1:0]   div_stage;
  logic [W-1:0]   lim_stage;

  assign sel    = ptb_decode(addr);
  assign cnt_we = we && (sel == SEL_CNT);

  // staging registers written by the bus
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_stage <= '0;
      lim_stage <= '0;
    end else if (we) begin
      if (sel == SEL_DIV) div_stage <= wdata;
      if (sel == SEL_LIM) lim_stage <= wdata;
    end
  end

  // active copies: loaded only on an update event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_act <= '0;
      lim_act <= '0;
    end else if (upd_evt) begin
      div_act <= div_stage;
      lim_act <= lim_stage;
    end
  end

  always_comb begin
    case (sel)
      SEL_CNT: rdata = cnt_q;
      SEL_DIV: rdata = div_stage;
      SEL_LIM: rdata = lim_stage;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/ptb_prescaler.sv
module ptb_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         restart,
  input  logic [W-1:0] div_act,
  output logic         tick,
  output logic [W-1:0] pcnt
);
  logic at_end;

  assign at_end = (pcnt >= div_act);
  assign tick   = en && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (restart) pcnt <= '0;
    else if (en)      pcnt <= at_end ? '0 : pcnt + 1'b1;
  end
endmodule

// File: rtl/ptb_counter.sv
module ptb_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] lim_act,
  input  logic         sw_upd,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  output logic [W-1:0] cnt_q,
  output logic         upd_evt,
  output logic         upd_pulse
);
  logic live;
  logic wrap;

  assign live    = tick && (lim_act != '0);
  assign wrap    = live && (cnt_q >= lim_act) && !cnt_we;
  assign upd_evt = sw_upd || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (sw_upd) cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_wdata;
    else if (live)   cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_pulse <= 1'b0;
    else        upd_pulse <= upd_evt;
  end
endmodule

// File: rtl/ptb_timebase.sv
module ptb_timebase
  import ptb_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sw_upd,
  input  logic [PTB_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              upd_pulse
);
  logic [W-1:0] div_act;
  logic [W-1:0] lim_act;
  logic [W-1:0] pcnt;
  logic [W-1:0] cnt_q;
  logic         cnt_we;
  logic         tick;
  logic         upd_evt;

  ptb_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (bus_addr),
    .we      (bus_we),
    .wdata   (bus_wdata),
    .upd_evt (upd_evt),
    .cnt_q   (cnt_q),
    .div_act (div_act),
    .lim_act (lim_act),
    .cnt_we  (cnt_we),
    .rdata   (bus_rdata)
  );

  ptb_prescaler #(.W(W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .restart (upd_evt),
    .div_act (div_act),
    .tick    (tick),
    .pcnt    (pcnt)
  );

  ptb_counter #(.W(W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .lim_act   (lim_act),
    .sw_upd    (sw_upd),
    .cnt_we    (cnt_we),
    .cnt_wdata (bus_wdata),
    .cnt_q     (cnt_q),
    .upd_evt   (upd_evt),
    .upd_pulse (upd_pulse)
  );
endmodule

// File: rtl/ptb_timebase_chk.sv
module ptb_timebase_chk
  import ptb_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              sw_upd,
  input logic [PTB_AW-1:0] bus_addr,
  input logic              bus_we,
  input logic [W-1:0]      cnt_q,
  input logic [W-1:0]      pcnt,
  input logic [W-1:0]      div_act,
  input logic [W-1:0]      lim_act,
  input logic              upd_pulse
);
  logic cnt_wr;
  assign cnt_wr = bus_we && (bus_addr == OFS_CNT);

  p_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_act == '0 && !cnt_wr && !sw_upd) |=> $stable(cnt_q));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr && !sw_upd) |=> ($stable(cnt_q) && $stable(pcnt)));

  p_shadow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(lim_act) || !$stable(div_act)) |-> upd_pulse);

  p_sw_upd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_upd |=> (upd_pulse && cnt_q == '0 && pcnt == '0));

  p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |-> (cnt_q == '0));
endmodule

bind ptb_timebase ptb_timebase_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .sw_upd    (sw_upd),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .cnt_q     (cnt_q),
  .pcnt      (pcnt),
  .div_act   (div_act),
  .lim_act   (lim_act),
  .upd_pulse (upd_pulse)
);

// File: tb/ptb_timebase_tb.sv
`timescale 1ns/100ps
module ptb_timebase_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        sw_upd = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        upd_pulse;

  int n_chk = 0;
  int n_bad = 0;
  int edge_n = 0;
  int exp_q[$];
  int u;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) edge_n <= edge_n + 1;

  ptb_timebase u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .sw_upd(sw_upd),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .upd_pulse(upd_pulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: one queued edge number per observed pulse (R8)
  always @(negedge clk) begin
    if (rst_n && upd_pulse) begin
      if (exp_q.size() == 0) chk("R8 unexpected pulse at edge", edge_n, -1);
      else chk("R8 pulse edge", edge_n, exp_q.pop_front());
    end
  end

  // all tasks are entered at a falling edge
  task automatic reg_wr(input logic [7:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input int exp);
    bus_addr = a;
    #1;
    chk(tag, int'(bus_rdata), exp);
  endtask

  task automatic wait_edge(input int k);
    while (edge_n < k) @(negedge clk);
  endtask

  task automatic sw_update(output int at);
    sw_upd = 1'b1;
    at = edge_n + 1;
    exp_q.push_back(at);
    @(negedge clk);
    sw_upd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1 counter", 8'h24, 0);
    rd("R1 divisor", 8'h28, 0);
    rd("R1 limit", 8'h2C, 0);
    chk("R1 pulse", int'(upd_pulse), 0);
    // R2 unmapped offset: write ignored, reads zero
    reg_wr(8'h20, 16'hBEEF);
    rd("R2 unmapped read", 8'h20, 0);
    rd("R2 counter untouched", 8'h24, 0);
    // R6 zero limit blocks counting
    en = 1'b1;
    repeat (20) @(negedge clk);
    rd("R6 blocked", 8'h24, 0);
    // R7 staged values read back; R4 not yet active
    reg_wr(8'h28, 16'd2);
    reg_wr(8'h2C, 16'd4);
    rd("R7 divisor stage", 8'h28, 2);
    rd("R7 limit stage", 8'h2C, 4);
    repeat (10) @(negedge clk);
    rd("R4 still blocked", 8'h24, 0);
    // R10 software update: period (4+1)*(2+1)=15
    sw_update(u);
    rd("R10 counter zero", 8'h24, 0);
    exp_q.push_back(u + 15);
    exp_q.push_back(u + 30);
    wait_edge(u + 7);
    rd("R3 count rate", 8'h24, 2);
    wait_edge(u + 15);
    rd("R5 wrapped", 8'h24, 0);
    // R4 new limit staged mid-period
    wait_edge(u + 20);
    reg_wr(8'h2C, 16'd1);
    rd("R7 new limit stage", 8'h2C, 1);
    wait_edge(u + 25);
    rd("R4 old limit still active", 8'h24, 3);
    // R12 after wrap at u+30: limit 1, period 6
    exp_q.push_back(u + 36);
    exp_q.push_back(u + 42);
    wait_edge(u + 33);
    rd("R12 new limit counting", 8'h24, 1);
    // R9 enable low holds
    wait_edge(u + 43);
    en = 1'b0;
    rd("R9 before hold", 8'h24, 0);
    wait_edge(u + 53);
    rd("R9 held counter", 8'h24, 0);
    exp_q.push_back(u + 58);
    en = 1'b1;
    wait_edge(u + 54);
    rd("R9 prescaler held", 8'h24, 0);
    wait_edge(u + 55);
    rd("R9 resumed", 8'h24, 1);
    // R11 counter write
    wait_edge(u + 58);
    exp_q.push_back(u + 61);
    reg_wr(8'h24, 16'h0100);
    rd("R11 written", 8'h24, 16'h0100);
    exp_q.push_back(u + 67);
    wait_edge(u + 63);
    reg_wr(8'h24, 16'd5);
    rd("R11 overrides advance", 8'h24, 5);
    wait_edge(u + 68);
    en = 1'b0;
    repeat (10) @(negedge clk);
    chk("R8 missing pulses", exp_q.size(), 0);
    finish_run();
  end
endmodule